// File: doc/BRIEF.md
# EEPROM Page Write Stager with Quarter-Array Protection

This block sits between a serial-bus slave front end and a byte-wide nonvolatile array. While a write transaction is open, it collects the data bytes into a page-sized staging buffer and marks each slot it fills. When the transaction closes with a STOP, it copies the marked slots into the array. The copy runs as a self-timed write cycle. During that cycle `busy_o` is high, and the front end uses it to refuse its device address, so a master can poll for completion.

The front end gives the block single-cycle event pulses: start of transaction, address load, data byte, and stop. On the array side the block drives a simple write strobe with an address and a data byte. A write-protect input shields one quarter of the address space. The `PROT_SIDE` parameter selects the quarter: the lowest quarter (array address bits [12:11] = 00) or the highest quarter (bits [12:11] = 11).

Top module: `page_commit_stage`

## Requirements
- R1: After reset `busy_o` is low and `mem_we_o` is low.
- R2: An address load sets the page to `addr_i[12:6]` and the column to `addr_i[5:0]`. Data byte n after the load is staged at column (`addr_i[5:0]` + n) mod 64 and is committed to array address {page, column}.
- R3: The column wraps from 63 to 0 within the same page. A later byte to a column already filled in the same transaction replaces the earlier byte.
- R4: A commit writes only the columns staged since the last START. It writes them in ascending column order, at most one per cycle. Column c is written in the (c+1)-th cycle after the cycle in which the STOP pulse is sampled.
- R5: A STOP starts a write cycle only if at least one data byte was received since the last START. A START followed by a STOP with no data leaves `busy_o` low and issues no writes.
- R6: `busy_o` rises in the cycle after the qualifying STOP. It stays high for exactly `WR_CYCLES` cycles and then clears by itself.
- R7: With `PROT_SIDE` = bottom and `wp_i` high, bytes whose array address has bits [12:11] = 00 are dropped without being written. They still count as data, so the write cycle still runs.
- R8: With `PROT_SIDE` = top and `wp_i` high, bytes whose array address has bits [12:11] = 11 are dropped. Bytes in the other quarters are written.
- R9: With `wp_i` low, bytes in every quarter are written.
- R10: While `busy_o` is high, START, address load, data byte and STOP pulses are ignored. Bytes offered during busy never reach the array.
- R11: A STOP that arrives after a completed commit, with no new data byte since that commit, starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_i | input | 1 | Write-protect level, sampled as each byte arrives |
| start_i | input | 1 | START seen for this device; clears staged bytes |
| addr_load_i | input | 1 | Word address is valid on `addr_i` |
| addr_i | input | AW | Word address (page and column) |
| wr_byte_i | input | 1 | Data byte is valid on `wr_data_i` |
| wr_data_i | input | DW | Received data byte |
| stop_i | input | 1 | STOP seen on the bus |
| busy_o | output | 1 | Write cycle in progress; front end must not acknowledge |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | AW | Array write address |
| mem_wdata_o | output | DW | Array write data |

## Verification
The bench builds two copies with `AW` = 13, `PAGE` = 64 and `WR_CYCLES` = 80. One copy guards the bottom quarter and the other guards the top quarter, and both receive the same stimulus. With this setup, one transaction shows the protected write being dropped on one copy and landing on the other. The short write cycle makes it possible to measure the exact busy length and to inject events in the middle of a cycle, while the column scan is still running. With the page at full size, a 66-byte burst exercises wrap-around and overwrite.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic {
    SIDE_BOTTOM = 1'b0,
    SIDE_TOP    = 1'b1
  } prot_side_e;

  localparam logic [1:0] QTR_LOW  = 2'b00;
  localparam logic [1:0] QTR_HIGH = 2'b11;
endpackage

// File: rtl/pcs_page_buf.sv
module pcs_page_buf #(
  parameter int DW   = 8,
  parameter int PAGE = 64,
  localparam int CW  = $clog2(PAGE)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic [CW-1:0] wr_col_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [CW-1:0] rd_col_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_vld_o
);
  logic [PAGE-1:0] vld_q;
  logic [DW-1:0]   data_q [PAGE];

  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        data_q[g] <= '0;
      end else if (clr_i) begin
        vld_q[g]  <= 1'b0;
      end else if (wr_i && wr_col_i == CW'(g)) begin
        vld_q[g]  <= 1'b1;
        data_q[g] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = data_q[rd_col_i];
  assign rd_vld_o  = vld_q[rd_col_i];

  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (vld_q == '0)); // R4
endmodule

// File: rtl/pcs_wp_guard.sv
module pcs_wp_guard
  import pcs_pkg::*;
#(
  parameter prot_side_e PROT_SIDE = SIDE_BOTTOM
) (
  input  logic       wp_i,
  input  logic [1:0] qtr_i,
  output logic       block_o
);
  logic hit;

  if (PROT_SIDE == SIDE_TOP) begin : g_top
    assign hit = (qtr_i == QTR_HIGH);
  end else begin : g_bottom
    assign hit = (qtr_i == QTR_LOW);
  end

  assign block_o = wp_i && hit;
endmodule

// File: rtl/pcs_commit_seq.sv
module pcs_commit_seq #(
  parameter int PAGE      = 64,
  parameter int WR_CYCLES = 80,   // must be >= PAGE
  localparam int CW = $clog2(PAGE),
  localparam int TW = $clog2(WR_CYCLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  output logic          busy_o,
  output logic          scan_o,
  output logic [CW-1:0] idx_o
);
  logic [TW-1:0] cnt_q;
  logic          scan_q;
  logic [CW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      scan_q <= 1'b0;
      idx_q  <= '0;
    end else if (go_i && cnt_q == '0) begin
      cnt_q  <= TW'(WR_CYCLES);
      scan_q <= 1'b1;
      idx_q  <= '0;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - TW'(1);
      if (scan_q) begin
        idx_q <= idx_q + CW'(1);
        if (idx_q == CW'(PAGE - 1)) scan_q <= 1'b0;
      end
    end
  end

  assign busy_o = (cnt_q != '0);
  assign scan_o = scan_q;
  assign idx_o  = idx_q;

  AST_GO_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && !busy_o) |=> (busy_o && scan_o && idx_o == '0)); // R6
  AST_SCAN_BEFORE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !scan_o); // R6
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_o && $past(scan_o)) |-> (idx_o == CW'($past(idx_o) + CW'(1)))); // R4
endmodule

// File: rtl/page_commit_stage.sv
module page_commit_stage
  import pcs_pkg::*;
#(
  parameter int         AW        = 13,
  parameter int         DW        = 8,
  parameter int         PAGE      = 64,
  parameter int         WR_CYCLES = 80,
  parameter prot_side_e PROT_SIDE = SIDE_BOTTOM
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wp_i,
  input  logic          start_i,
  input  logic          addr_load_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_byte_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          stop_i,
  output logic          busy_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o
);
  localparam int CW  = $clog2(PAGE);
  localparam int PGW = AW - CW;

  logic [PGW-1:0] page_q;
  logic [CW-1:0]  col_q;
  logic           got_q;
  logic           busy, accept, block, buf_wr, buf_clr, go;
  logic           scan, rd_vld;
  logic [CW-1:0]  idx;
  logic [DW-1:0]  rd_data;

  assign accept  = !busy;
  assign buf_wr  = wr_byte_i && accept && !block;
  assign buf_clr = start_i && accept;
  assign go      = stop_i && accept && got_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      col_q  <= '0;
    end else if (accept) begin
      if (addr_load_i) begin
        page_q <= addr_i[AW-1:CW];
        col_q  <= addr_i[CW-1:0];
      end else if (wr_byte_i) begin
        col_q  <= col_q + CW'(1);  // wraps inside the page
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    got_q <= 1'b0;
    else if (buf_clr || go)         got_q <= 1'b0;
    else if (wr_byte_i && accept)   got_q <= 1'b1;  // dropped bytes still count
  end

  pcs_wp_guard #(.PROT_SIDE(PROT_SIDE)) u_guard (
    .wp_i    (wp_i),
    .qtr_i   (page_q[PGW-1:PGW-2]),
    .block_o (block)
  );

  pcs_page_buf #(.DW(DW), .PAGE(PAGE)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (buf_clr),
    .wr_i      (buf_wr),
    .wr_col_i  (col_q),
    .wr_data_i (wr_data_i),
    .rd_col_i  (idx),
    .rd_data_o (rd_data),
    .rd_vld_o  (rd_vld)
  );

  pcs_commit_seq #(.PAGE(PAGE), .WR_CYCLES(WR_CYCLES)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .busy_o (busy),
    .scan_o (scan),
    .idx_o  (idx)
  );

  assign busy_o      = busy;
  assign mem_we_o    = scan && rd_vld;
  assign mem_addr_o  = {page_q, idx};
  assign mem_wdata_o = rd_data;

  AST_WE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o); // R4
  AST_BUSY_FROM_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i)); // R5
  AST_BUSY_DEAF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(page_q) && !got_q)); // R10
endmodule

// File: tb/page_commit_stage_tb.sv
`timescale 1ns/1ps
module page_commit_stage_tb;
  import pcs_pkg::*;

  localparam int AW = 13, DW = 8, PAGE = 64, WR = 80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wp = 1'b0, start = 1'b0, aload = 1'b0, wbyte = 1'b0, stop = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic busy_lo, we_lo, busy_hi, we_hi;
  logic [AW-1:0] ma_lo, ma_hi;
  logic [DW-1:0] md_lo, md_hi;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [AW-1:0] lo_a [128];
  logic [DW-1:0] lo_d [128];
  logic [AW-1:0] hi_a [128];
  logic [DW-1:0] hi_d [128];
  int lo_n = 0, hi_n = 0;

  bit            ev_lo [PAGE];
  bit            ev_hi [PAGE];
  logic [DW-1:0] ed    [PAGE];
  logic [AW-7:0] epage;

  always #2 clk = ~clk;

  page_commit_stage #(.AW(AW), .DW(DW), .PAGE(PAGE), .WR_CYCLES(WR), .PROT_SIDE(SIDE_BOTTOM)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wp_i(wp), .start_i(start), .addr_load_i(aload), .addr_i(addr),
    .wr_byte_i(wbyte), .wr_data_i(wdata), .stop_i(stop), .busy_o(busy_lo),
    .mem_we_o(we_lo), .mem_addr_o(ma_lo), .mem_wdata_o(md_lo));

  page_commit_stage #(.AW(AW), .DW(DW), .PAGE(PAGE), .WR_CYCLES(WR), .PROT_SIDE(SIDE_TOP)) u_dut_hi (
    .clk_i(clk), .rst_ni(rst_n), .wp_i(wp), .start_i(start), .addr_load_i(aload), .addr_i(addr),
    .wr_byte_i(wbyte), .wr_data_i(wdata), .stop_i(stop), .busy_o(busy_hi),
    .mem_we_o(we_hi), .mem_addr_o(ma_hi), .mem_wdata_o(md_hi));

  always @(negedge clk) begin
    if (we_lo && lo_n < 128) begin lo_a[lo_n] = ma_lo; lo_d[lo_n] = md_lo; lo_n++; end
    if (we_hi && hi_n < 128) begin hi_a[hi_n] = ma_hi; hi_d[hi_n] = md_hi; hi_n++; end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1; @(negedge clk) start = 1'b0;
  endtask

  task automatic pulse_addr(input logic [AW-1:0] a);
    @(negedge clk) begin aload = 1'b1; addr = a; end
    @(negedge clk) aload = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop = 1'b1; @(negedge clk) stop = 1'b0;
  endtask

  task automatic send_bytes(input int n, input logic [DW-1:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) begin wbyte = 1'b1; wdata = base + DW'(i); end
    end
    @(negedge clk) wbyte = 1'b0;
  endtask

  // builds the expected page image for both protection sides
  task automatic model(input logic [AW-1:0] a, input int n, input logic [DW-1:0] base, input logic w);
    bit pl, ph;
    epage = a[AW-1:6];
    pl = w && (a[AW-1:AW-2] == 2'b00);
    ph = w && (a[AW-1:AW-2] == 2'b11);
    for (int c = 0; c < PAGE; c++) begin ev_lo[c] = 0; ev_hi[c] = 0; end
    for (int i = 0; i < n; i++) begin
      int c;
      c = (int'(a[5:0]) + i) % PAGE;
      ed[c] = base + DW'(i);
      if (!pl) ev_lo[c] = 1;
      if (!ph) ev_hi[c] = 1;
    end
  endtask

  task automatic compare_logs(input string req);
    int k;
    k = 0;
    for (int c = 0; c < PAGE; c++) if (ev_lo[c]) begin
      if (k < lo_n) begin
        chk({req, " lo addr"}, int'(lo_a[k]), int'({epage, 6'(c)}));
        chk({req, " lo data"}, int'(lo_d[k]), int'(ed[c]));
      end
      k++;
    end
    chk({req, " lo count"}, lo_n, k);
    k = 0;
    for (int c = 0; c < PAGE; c++) if (ev_hi[c]) begin
      if (k < hi_n) begin
        chk({req, " hi addr"}, int'(hi_a[k]), int'({epage, 6'(c)}));
        chk({req, " hi data"}, int'(hi_d[k]), int'(ed[c]));
      end
      k++;
    end
    chk({req, " hi count"}, hi_n, k);
  endtask

  // full transaction; checks busy length and committed writes
  task automatic txn(input string req, input logic [AW-1:0] a, input int n,
                     input logic [DW-1:0] base, input logic w);
    int len;
    lo_n = 0; hi_n = 0;
    wp = w;
    model(a, n, base, w);
    pulse_start();
    pulse_addr(a);
    if (n > 0) send_bytes(n, base);
    pulse_stop();
    len = 0;
    while (busy_lo) begin len++; @(negedge clk); end
    chk({req, " R6 busy length"}, len, (n > 0) ? WR : 0);
    chk({req, " busy copies agree"}, int'(busy_hi), 0);
    repeat (3) @(negedge clk);
    compare_logs(req);
    wp = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 busy after reset", int'(busy_lo), 0);
    chk("R1 we after reset", int'(we_lo), 0);
    chk("R1 busy after reset (top side)", int'(busy_hi), 0);
  endtask

  task automatic t_basic();
    txn("R2 R4 R9 basic", 13'h0105, 3, 8'h30, 1'b0);
  endtask

  task automatic t_first_write_cycle();
    int cyc;
    lo_n = 0; hi_n = 0;
    pulse_start();
    pulse_addr(13'h0240);
    send_bytes(1, 8'h5A);
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    chk("R4 column 0 written first cycle", int'(we_lo), 1);
    chk("R4 first write address", int'(ma_lo), 13'h0240);
    cyc = 0;
    while (busy_lo) begin cyc++; @(negedge clk); end
    chk("R6 busy self-clears", cyc, WR);
  endtask

  task automatic t_wrap();
    txn("R3 wrap overwrite", 13'h02BE, 66, 8'h80, 1'b0);
  endtask

  task automatic t_protect();
    txn("R7 bottom quarter", 13'h0040, 4, 8'h10, 1'b1);
    txn("R8 top quarter", 13'h1F80, 4, 8'h20, 1'b1);
    txn("R9 top quarter unprotected", 13'h1FC0, 2, 8'h60, 1'b0);
  endtask

  task automatic t_no_data();
    txn("R5 start stop no data", 13'h0300, 0, 8'h00, 1'b0);
  endtask

  task automatic t_busy_ignore();
    int guard;
    lo_n = 0; hi_n = 0;
    model(13'h0414, 2, 8'hA0, 1'b0);
    pulse_start();
    pulse_addr(13'h0414);
    send_bytes(2, 8'hA0);
    pulse_stop();
    chk("R10 busy active", int'(busy_lo), 1);
    pulse_start();
    pulse_addr(13'h0428);
    send_bytes(2, 8'hEE);
    pulse_stop();
    guard = 0;
    while (busy_lo && guard < 1000) begin guard++; @(negedge clk); end
    repeat (3) @(negedge clk);
    compare_logs("R10 events during busy");
    lo_n = 0; hi_n = 0;
    pulse_stop();
    repeat (2) @(negedge clk);
    chk("R11 repeat stop no busy", int'(busy_lo), 0);
    chk("R11 repeat stop no writes", lo_n, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_first_write_cycle();
    t_wrap();
    t_protect();
    t_no_data();
    t_busy_ignore();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule